// File: doc/BRIEF.md
# Two-Wire Serial Memory Target Engine

This block is the target side of a two-wire serial memory bus. A fast system clock samples the clock and data lines through synchronizers. The block spots bus start and stop events, takes in an 8-bit device select byte, and compares it against a fixed 1010 type prefix and three strap inputs. If the byte matches, the block takes a two-byte word address and then either stores incoming data bytes or streams stored bytes back to the master. It answers each byte on the ninth clock. The data line is driven open-drain, through an active-high pull-down enable.

The memory array sits outside the block. The block reaches it through a registered word address, a single-cycle write strobe with its data, and a single-cycle read strobe. The array must return read data one clock after the read strobe. An internal word-address counter holds its value between transfers. After a write it advances within a 64-byte page, and after a read it advances across the whole array. A write of only the two address bytes, followed by a repeated start and a read select byte, performs a random read.

Top module: `i2c_eeprom_target`

## Requirements
- R1: After reset the pull-down enable and both memory strobes are low. A stop returns the block to idle, and bytes clocked in without a new start get no acknowledge.
- R2: A select byte of 1010, then the three strap bits, then the direction bit (MSB first) is acknowledged by pulling the data line low for the ninth clock.
- R3: A select byte with the wrong type prefix or wrong strap bits gets no acknowledge. The block then ignores all traffic up to the next start, and issues no write.
- R4: In a write, the two word-address bytes (high byte first) are each acknowledged. Only the low 15 bits are kept, so bit 15 has no effect.
- R5: Each data byte of a write is acknowledged and stored at the current word address.
- R6: During a write the address advances only in its low 6 bits, so a byte after offset 63 of a page lands at offset 0 of the same page.
- R7: A read (direction bit 1) returns bytes MSB first, starting at the current word address. That address is the last byte accessed plus one.
- R8: While the master acknowledges, read bytes keep coming from consecutive addresses, and the address wraps from 0x7FFF to 0x0000.
- R9: After the master withholds its acknowledge, the block releases the data line and drives nothing on later clocks.
- R10: A write of only the two address bytes, then a repeated start and a read select byte, returns the byte at that address.
- R11: A start at any point, including mid-byte, aborts the current transfer without storing the partial byte, and begins a new select byte.
- R12: The pull-down enable changes only while the synchronized clock line is low.
- R13: A read transfer that ends with a stop produces no write strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| strap_i | input | 3 | Strap bits the select byte must match |
| sda_oe | output | 1 | 1 pulls the data line low, 0 releases it |
| mem_addr_o | output | 15 | Current word address for the array |
| mem_wr_o | output | 1 | Single-cycle write strobe |
| mem_wdata_o | output | 8 | Byte to store, valid with the write strobe |
| mem_rd_o | output | 1 | Single-cycle read strobe |
| mem_rdata_i | input | 8 | Array output, valid the cycle after the read strobe |

## Verification
The bench writes three bytes starting at the second-to-last offset of a page. A design that carried the increment into the upper address bits would leave the third byte on the next page, and the bench reads back offset 0 and the next page to catch this. A sequential read that starts at 0x7FFF must continue at 0x0000, and the following current-address read must return the byte at 0x0001. This exposes a counter that wraps per page on reads, or that fails to advance past the last byte read. The bench also sends mismatched select bytes, a repeated start in the middle of a data byte, and extra clocks after a withheld acknowledge. A design that acknowledged a foreign select byte, stored a partial byte, or kept driving after the acknowledge was withheld would show a spurious acknowledge, a wrong write count, or a read value other than 0xFF.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_RX,
        S_RXACK,
        S_TX,
        S_TXACK
    } tgt_state_e;

    typedef enum logic [1:0] {
        K_DEV,
        K_AHI,
        K_ALO,
        K_DATA
    } rx_kind_e;

    localparam int          BYTE_W   = 8;
    localparam logic [3:0]  DEV_TYPE = 4'b1010;

    function automatic rx_kind_e next_kind(input rx_kind_e k);
        case (k)
            K_DEV:   return K_AHI;
            K_AHI:   return K_ALO;
            default: return K_DATA;
        endcase
    endfunction

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
    parameter int LINES  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] raw_i,
    output logic [LINES-1:0] sync_o,
    output logic [LINES-1:0] prev_o
);
    localparam int DEPTH = STAGES + 1;

    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic [DEPTH-1:0] pipe_d, pipe_q;

        always_comb begin
            pipe_d = {pipe_q[DEPTH-2:0], raw_i[g]};
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pipe_q <= '1;
            else        pipe_q <= pipe_d;
        end

        assign sync_o[g] = pipe_q[STAGES-1];
        assign prev_o[g] = pipe_q[STAGES];
    end

endmodule

// File: rtl/i2c_addr_ctr.sv
module i2c_addr_ctr #(
    parameter int ADDR_W = 15,
    parameter int PAGE_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [ADDR_W-1:0] load_val_i,
    input  logic              inc_page_i,
    input  logic              inc_lin_i,
    output logic [ADDR_W-1:0] addr_o
);
    logic [ADDR_W-1:0] addr_d, addr_q;
    logic [ADDR_W-1:0] page_next;

    if (PAGE_W >= ADDR_W) begin : g_flat
        assign page_next = addr_q + 1'b1;
    end else begin : g_paged
        logic [PAGE_W-1:0] low_next;
        assign low_next  = addr_q[PAGE_W-1:0] + 1'b1;
        assign page_next = {addr_q[ADDR_W-1:PAGE_W], low_next};
    end

    always_comb begin
        addr_d = addr_q;
        if (load_i)          addr_d = load_val_i;
        else if (inc_page_i) addr_d = page_next;
        else if (inc_lin_i)  addr_d = addr_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) addr_q <= '0;
        else        addr_q <= addr_d;
    end

    assign addr_o = addr_q;

endmodule

// File: rtl/i2c_eeprom_target.sv
module i2c_eeprom_target
    import i2c_tgt_pkg::*;
#(
    parameter int ADDR_W    = 15,
    parameter int PAGE_W    = 6,
    parameter int SYNC_STG  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic [2:0]        strap_i,
    output logic              sda_oe,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic              mem_wr_o,
    output logic [7:0]        mem_wdata_o,
    output logic              mem_rd_o,
    input  logic [7:0]        mem_rdata_i
);
    localparam int         AHI_W    = ADDR_W - BYTE_W;
    localparam int         CNT_W    = $clog2(BYTE_W + 1);
    localparam logic [CNT_W-1:0] BIT_LAST = CNT_W'(BYTE_W);
    localparam logic [CNT_W-1:0] BIT_ONE  = CNT_W'(1);

    typedef struct packed {
        tgt_state_e       st;
        rx_kind_e         kind;
        logic [CNT_W-1:0] cnt;
        logic [7:0]       sh;
        logic [7:0]       tx;
        logic [AHI_W-1:0] ahi;
        logic             rw;
        logic             oe;
        logic             wr;
        logic             rd;
        logic             ld;
        logic             ack;
    } tgt_regs_t;

    localparam tgt_regs_t REGS_RST = '{
        st: S_IDLE, kind: K_DEV, cnt: '0, sh: '0, tx: '0, ahi: '0,
        rw: 1'b0, oe: 1'b0, wr: 1'b0, rd: 1'b0, ld: 1'b0, ack: 1'b0
    };

    tgt_regs_t d, q;

    // line synchronizers: bit 1 = clock line, bit 0 = data line
    logic [1:0] ln_s, ln_p;
    logic       scl_s, scl_p, sda_s, sda_p;
    logic       scl_rise, scl_fall, start_det, stop_det;

    i2c_line_sync #(.LINES(2), .STAGES(SYNC_STG)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw_i  ({scl_i, sda_i}),
        .sync_o (ln_s),
        .prev_o (ln_p)
    );

    assign scl_s     = ln_s[1];
    assign scl_p     = ln_p[1];
    assign sda_s     = ln_s[0];
    assign sda_p     = ln_p[0];
    assign scl_rise  = scl_s & ~scl_p;
    assign scl_fall  = ~scl_s & scl_p;
    assign start_det = scl_s & scl_p & sda_p & ~sda_s;
    assign stop_det  = scl_s & scl_p & ~sda_p & sda_s;

    // word-address counter
    logic              ctr_load;
    logic [ADDR_W-1:0] ctr_addr;

    i2c_addr_ctr #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_ctr (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (ctr_load),
        .load_val_i ({q.ahi, q.sh}),
        .inc_page_i (q.wr),
        .inc_lin_i  (q.ld),
        .addr_o     (ctr_addr)
    );

    logic dev_hit;
    assign dev_hit = (q.sh[7:4] == DEV_TYPE) && (q.sh[3:1] == strap_i);

    always_comb begin
        d        = q;
        d.wr     = 1'b0;
        d.rd     = 1'b0;
        d.ld     = q.rd;
        ctr_load = 1'b0;

        if (q.ld) d.tx = mem_rdata_i;

        if (start_det) begin
            d.st   = S_RX;
            d.kind = K_DEV;
            d.cnt  = '0;
            d.oe   = 1'b0;
            d.ack  = 1'b0;
        end else if (stop_det) begin
            d.st = S_IDLE;
            d.oe = 1'b0;
        end else begin
            case (q.st)
                S_RX: begin
                    if (scl_rise && q.cnt != BIT_LAST) begin
                        d.sh  = {q.sh[6:0], sda_s};
                        d.cnt = q.cnt + BIT_ONE;
                    end else if (scl_fall && q.cnt == BIT_LAST) begin
                        d.st = S_RXACK;
                        d.oe = 1'b1;
                        case (q.kind)
                            K_DEV: begin
                                if (dev_hit) begin
                                    d.rw = q.sh[0];
                                    d.rd = q.sh[0];
                                end else begin
                                    d.st = S_IDLE;
                                    d.oe = 1'b0;
                                end
                            end
                            K_AHI:   d.ahi    = q.sh[AHI_W-1:0];
                            K_ALO:   ctr_load = 1'b1;
                            default: d.wr     = 1'b1;
                        endcase
                    end
                end
                S_RXACK: begin
                    if (scl_fall) begin
                        d.oe  = 1'b0;
                        d.cnt = '0;
                        if (q.kind == K_DEV && q.rw) begin
                            d.st  = S_TX;
                            d.oe  = ~q.tx[7];
                            d.tx  = {q.tx[6:0], 1'b0};
                            d.cnt = BIT_ONE;
                        end else begin
                            d.st   = S_RX;
                            d.kind = next_kind(q.kind);
                        end
                    end
                end
                S_TX: begin
                    if (scl_fall) begin
                        if (q.cnt == BIT_LAST) begin
                            d.oe  = 1'b0;
                            d.st  = S_TXACK;
                            d.ack = 1'b0;
                        end else begin
                            d.oe  = ~q.tx[7];
                            d.tx  = {q.tx[6:0], 1'b0};
                            d.cnt = q.cnt + BIT_ONE;
                        end
                    end
                end
                S_TXACK: begin
                    if (scl_rise) begin
                        if (!sda_s) begin
                            d.ack = 1'b1;
                            d.rd  = 1'b1;
                        end
                    end else if (scl_fall) begin
                        if (q.ack) begin
                            d.st  = S_TX;
                            d.oe  = ~q.tx[7];
                            d.tx  = {q.tx[6:0], 1'b0};
                            d.cnt = BIT_ONE;
                        end else begin
                            d.st = S_IDLE;
                        end
                    end
                end
                default: begin
                    d.oe = 1'b0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= REGS_RST;
        else        q <= d;
    end

    // observation points for the bound checker
    tgt_state_e st_q;
    logic       rw_q;
    assign st_q = q.st;
    assign rw_q = q.rw;

    assign sda_oe      = q.oe;
    assign mem_addr_o  = ctr_addr;
    assign mem_wr_o    = q.wr;
    assign mem_wdata_o = q.sh;
    assign mem_rd_o    = q.rd;

endmodule

// File: rtl/i2c_eeprom_target_chk.sv
module i2c_eeprom_target_chk
    import i2c_tgt_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       sda_oe,
    input logic       scl_s,
    input logic       stop_det,
    input tgt_state_e st,
    input logic       rw,
    input logic       mem_wr,
    input logic       mem_rd
);

    a_r12_oe_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> !$past(scl_s))
        else $error("R12 pull-down enable changed while clock high");

    a_r1_stop_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> (st == S_IDLE))
        else $error("R1 stop did not return to idle");

    a_r3_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_IDLE) |-> !sda_oe)
        else $error("R3 data line driven while idle");

    a_r13_wr_only_in_write: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |-> (st == S_RXACK && !rw))
        else $error("R13 write strobe outside a write acknowledge");

    a_r5_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_wr && mem_rd))
        else $error("R5 read and write strobes together");

    a_r7_rd_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |=> !mem_rd)
        else $error("R7 read strobe longer than one cycle");

endmodule

bind i2c_eeprom_target i2c_eeprom_target_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .sda_oe   (sda_oe),
    .scl_s    (scl_s),
    .stop_det (stop_det),
    .st       (st_q),
    .rw       (rw_q),
    .mem_wr   (mem_wr_o),
    .mem_rd   (mem_rd_o)
);

// File: tb/i2c_eeprom_target_tb.sv
module i2c_eeprom_target_tb;

    localparam int Q = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        m_scl = 1'b1;
    logic        m_sda = 1'b1;
    logic [2:0]  strap = 3'b101;
    logic        sda_oe;
    logic [14:0] mem_addr;
    logic        mem_wr, mem_rd;
    logic [7:0]  mem_wdata;
    logic [7:0]  mem_rdata;
    wire         sda_line = m_sda & ~sda_oe;

    int n_run = 0, n_fail = 0, wr_cnt = 0, r12_bad = 0, oe_moves = 0;
    logic [14:0] last_wr_addr;
    logic        done = 1'b0;
    logic [7:0]  mem [256];

    always #4 clk = ~clk;

    i2c_eeprom_target u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (m_scl),
        .sda_i      (sda_line),
        .strap_i    (strap),
        .sda_oe     (sda_oe),
        .mem_addr_o (mem_addr),
        .mem_wr_o   (mem_wr),
        .mem_wdata_o(mem_wdata),
        .mem_rd_o   (mem_rd),
        .mem_rdata_i(mem_rdata)
    );

    // array model: one-cycle read latency, 256 entries indexed by low address bits
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) mem[i] <= 8'(i) ^ 8'h5A;
            mem_rdata <= '0;
        end else begin
            if (mem_wr) begin
                mem[mem_addr[7:0]] <= mem_wdata;
                wr_cnt       <= wr_cnt + 1;
                last_wr_addr <= mem_addr;
            end
            if (mem_rd) mem_rdata <= mem[mem_addr[7:0]];
        end
    end

    // R12 monitor: the enable may only move while the bus clock is low
    logic oe_prev = 1'b0;
    always @(negedge clk) begin
        if (sda_oe !== oe_prev) begin
            oe_moves++;
            if (m_scl) r12_bad++;
        end
        oe_prev = sda_oe;
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic half();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        m_sda = 1'b1; half();
        m_scl = 1'b1; half();
        m_sda = 1'b0; half();
        m_scl = 1'b0; half();
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; half();
        m_scl = 1'b1; half();
        m_sda = 1'b1; half();
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        for (int i = 7; i > 7 - n; i--) begin
            m_sda = b[i]; half();
            m_scl = 1'b1; half();
            m_scl = 1'b0; half();
        end
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        send_bits(b, 8);
        m_sda = 1'b1; half();
        m_scl = 1'b1; half();
        ack = ~sda_line;
        m_scl = 1'b0; half();
    endtask

    task automatic recv_byte(output logic [7:0] b, input logic give_ack);
        b = '0;
        m_sda = 1'b1;
        for (int i = 0; i < 8; i++) begin
            half();
            m_scl = 1'b1; half();
            b = {b[6:0], sda_line};
            m_scl = 1'b0;
        end
        m_sda = ~give_ack; half();
        m_scl = 1'b1; half();
        m_scl = 1'b0; half();
        m_sda = 1'b1;
    endtask

    task automatic wr_byte(input logic [15:0] a, input logic [7:0] v, output logic [3:0] acks);
        logic k;
        bus_start();
        send_byte(8'hAA, k); acks[3] = k;
        send_byte(a[15:8], k); acks[2] = k;
        send_byte(a[7:0], k);  acks[1] = k;
        send_byte(v, k);       acks[0] = k;
        bus_stop();
    endtask

    task automatic rd_rand(input logic [15:0] a, output logic [7:0] v, output logic [3:0] acks);
        logic k;
        bus_start();
        send_byte(8'hAA, k); acks[3] = k;
        send_byte(a[15:8], k); acks[2] = k;
        send_byte(a[7:0], k);  acks[1] = k;
        bus_start();
        send_byte(8'hAB, k); acks[0] = k;
        recv_byte(v, 1'b0);
        bus_stop();
    endtask

    // {op (1 = random read), word address, data}
    localparam logic [24:0] VEC [9] = '{
        {1'b0, 16'h0010, 8'hA1},
        {1'b0, 16'h0011, 8'h3C},
        {1'b1, 16'h0010, 8'hA1},
        {1'b1, 16'h0011, 8'h3C},
        {1'b0, 16'h2A55, 8'h00},
        {1'b1, 16'h2A55, 8'h00},
        {1'b0, 16'h7FFE, 8'hFF},
        {1'b1, 16'h7FFE, 8'hFF},
        {1'b1, 16'h0020, 8'h7A}
    };

    initial begin
        logic [3:0] acks;
        logic [7:0] b0, b1;
        logic       k;
        int         snap;

        repeat (5) @(negedge clk);
        check("R1 reset enable", {31'd0, sda_oe}, 32'd0);
        check("R1 reset strobes", {30'd0, mem_wr, mem_rd}, 32'd0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        for (int i = 0; i < 9; i++) begin
            if (VEC[i][24] == 1'b0) begin
                wr_byte(VEC[i][23:8], VEC[i][7:0], acks);
                check("R2 select ack", {31'd0, acks[3]}, 32'd1);
                check("R4 address acks", {30'd0, acks[2:1]}, 32'd3);
                check("R5 data ack", {31'd0, acks[0]}, 32'd1);
                check("R5 write address", {17'd0, last_wr_addr}, {17'd0, VEC[i][22:8]});
            end else begin
                rd_rand(VEC[i][23:8], b0, acks);
                check("R10 random read acks", {28'd0, acks}, 32'hF);
                check("R10 random read data", {24'd0, b0}, {24'd0, VEC[i][7:0]});
            end
        end

        // R8: sequential read across the top of the array
        bus_start();
        send_byte(8'hAA, k); send_byte(8'h7F, k); send_byte(8'hFF, k);
        bus_start();
        send_byte(8'hAB, k);
        recv_byte(b0, 1'b1);
        recv_byte(b1, 1'b0);
        bus_stop();
        check("R8 byte at 0x7FFF", {24'd0, b0}, 32'hA5);
        check("R8 wrap to 0x0000", {24'd0, b1}, 32'h5A);

        // R7: current-address read continues at 0x0001
        bus_start();
        send_byte(8'hAB, k);
        check("R7 read select ack", {31'd0, k}, 32'd1);
        recv_byte(b0, 1'b0);
        bus_stop();
        check("R7 current address data", {24'd0, b0}, 32'h5B);

        // R4: bit 15 of the word address has no effect
        rd_rand(16'h8012, b0, acks);
        check("R4 top bit ignored", {24'd0, b0}, 32'h48);

        // R6: page roll-over during a multi-byte write
        bus_start();
        send_byte(8'hAA, k); send_byte(8'h01, k); send_byte(8'h3E, k);
        send_byte(8'h11, k); send_byte(8'h22, k); send_byte(8'h33, k);
        bus_stop();
        check("R6 third byte address", {17'd0, last_wr_addr}, 32'h0100);
        rd_rand(16'h0100, b0, acks);
        check("R6 page offset 0", {24'd0, b0}, 32'h33);
        rd_rand(16'h0140, b0, acks);
        check("R6 next page untouched", {24'd0, b0}, 32'h1A);

        // R3: foreign select bytes
        snap = wr_cnt;
        bus_start();
        send_byte(8'hA0, k);
        check("R3 wrong strap no ack", {31'd0, k}, 32'd0);
        send_byte(8'h00, k); send_byte(8'h00, k); send_byte(8'h55, k);
        check("R3 later bytes no ack", {31'd0, k}, 32'd0);
        bus_stop();
        bus_start();
        send_byte(8'hBA, k);
        check("R3 wrong prefix no ack", {31'd0, k}, 32'd0);
        bus_stop();
        check("R3 no write", wr_cnt - snap, 32'd0);

        // R1: no start after a stop -> ignored
        send_byte(8'hAA, k);
        check("R1 no ack without start", {31'd0, k}, 32'd0);
        bus_stop();

        // R11: repeated start in the middle of a data byte
        snap = wr_cnt;
        bus_start();
        send_byte(8'hAA, k); send_byte(8'h00, k); send_byte(8'h30, k);
        send_bits(8'h77, 4);
        bus_start();
        send_byte(8'hAA, k);
        check("R11 new select acked", {31'd0, k}, 32'd1);
        send_byte(8'h00, k); send_byte(8'h30, k); send_byte(8'h99, k);
        bus_stop();
        check("R11 single write", wr_cnt - snap, 32'd1);
        rd_rand(16'h0030, b0, acks);
        check("R11 stored byte", {24'd0, b0}, 32'h99);

        // R9 / R13: read ended by a withheld acknowledge, then extra clocks
        snap = wr_cnt;
        bus_start();
        send_byte(8'hAB, k);
        recv_byte(b0, 1'b0);
        recv_byte(b1, 1'b0);
        bus_stop();
        check("R7 address after random read", {24'd0, b0}, 32'h6B);
        check("R9 released after nack", {24'd0, b1}, 32'hFF);
        check("R13 no write in read", wr_cnt - snap, 32'd0);

        check("R12 enable moved only with clock low", r12_bad, 32'd0);
        check("R12 enable activity seen", {31'd0, oe_moves > 0}, 32'd1);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule